// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Operation Decoder

This block is the integer execution unit of a simple load/store processor pipeline. Each cycle it takes two operand words and computes one of five operations: bitwise AND, bitwise OR, addition, subtraction, or signed set-on-less-than. It is purely combinational. The result word and three status flags are valid in the same cycle the inputs are presented.

The operation is picked by a two-level decode:

- A 2-bit operation class comes from the main instruction decoder.
- A 6-bit function field comes from register-type instructions.
- These reduce to an internal 3-bit control word: one operand-negate bit plus a 2-bit result select.

Subtraction reuses the adder. The negate bit both inverts operand B and injects the low-order carry.

Set-on-less-than takes the sign of the difference, corrected by the overflow indication. This makes the comparison right across the whole signed range.

Top module: `alu_core`

## Requirements
- R1: Class 00 selects addition and class 01 selects subtraction. Class 11 is unused and selects addition. Class 10 decodes funct[3:0] as follows: 0000 add, 0010 subtract, 0100 AND, 0101 OR, 1010 set-on-less-than. Any other funct value selects addition. funct[5:4] are ignored.
- R2: AND yields `a & b` and OR yields `a | b`, bit for bit.
- R3: Addition yields `(a + b) mod 2^32`. carry_out is the carry out of bit 31.
- R4: Subtraction yields `(a - b) mod 2^32`, computed as `a + ~b + 1`. carry_out is the carry out of bit 31 of that sum, so it is 1 exactly when `a >= b` unsigned.
- R5: For add, subtract and set-on-less-than, overflow is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. For subtract and set-on-less-than this is the signed overflow of the subtraction.
- R6: Set-on-less-than yields 1 in bit 0 when `a < b` as signed two's-complement values, and 0 otherwise. Bits 31..1 are always 0, even when the subtraction overflows.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: For AND and OR, overflow and carry_out are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| alu_op | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of register-type instructions |
| result | output | 32 | Computed result word |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of the adder path |
| carry_out | output | 1 | Carry out of the most significant adder bit |

## Verification
Set-on-less-than and overflow detection meet in the same evaluation. When the subtraction overflows, the raw sign of the difference is wrong, and the comparison must use the corrected value.

The bench provokes this with operands of opposite sign near the ends of the range, for example the most negative value against 1, and the most positive value against -1. It judges the result bit against a signed comparison done with integers, and judges the overflow flag against a sign-based model.

A second coincidence is zero together with carry_out on a subtraction of equal operands. The bench checks it against the arithmetic expectation that both flags are set.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } res_sel_e;

  typedef struct packed {
    logic     negate;
    res_sel_e sel;
  } alu_ctrl_t;

  localparam alu_ctrl_t CTRL_ADD = '{negate: 1'b0, sel: SEL_SUM};
  localparam alu_ctrl_t CTRL_SUB = '{negate: 1'b1, sel: SEL_SUM};
  localparam alu_ctrl_t CTRL_AND = '{negate: 1'b0, sel: SEL_AND};
  localparam alu_ctrl_t CTRL_OR  = '{negate: 1'b0, sel: SEL_OR};
  localparam alu_ctrl_t CTRL_SLT = '{negate: 1'b1, sel: SEL_SLT};
endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
#(
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         alu_op,
  input  logic [FUNCT_W-1:0] funct,
  output alu_ctrl_t          ctrl
);
  localparam int USED_W = 4;

  logic [USED_W-1:0] fn_lo;
  logic              unused_fn_hi;

  assign fn_lo        = funct[USED_W-1:0];
  assign unused_fn_hi = ^funct[FUNCT_W-1:USED_W];

  always_comb begin
    ctrl = CTRL_ADD;
    unique case (alu_op)
      2'b00: ctrl = CTRL_ADD;
      2'b01: ctrl = CTRL_SUB;
      2'b10: begin
        case (fn_lo)
          4'b0000: ctrl = CTRL_ADD;
          4'b0010: ctrl = CTRL_SUB;
          4'b0100: ctrl = CTRL_AND;
          4'b0101: ctrl = CTRL_OR;
          4'b1010: ctrl = CTRL_SLT;
          default: ctrl = CTRL_ADD;
        endcase
      end
      default: ctrl = CTRL_ADD;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             negate,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_eff;

  // One negate line feeds both the inversion and the bit-0 carry.
  assign carry[0] = negate;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop;
    assign b_eff[i]   = b[i] ^ negate;
    assign prop       = a[i] ^ b_eff[i];
    assign sum[i]     = prop ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (prop & carry[i]);
  end

  assign c_out = carry[WIDTH];
  assign ovf   = carry[MSB] ^ carry[WIDTH];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] sum,
  input  logic             ovf,
  output logic [WIDTH-1:0] result
);
  localparam int MSB = WIDTH - 1;

  logic less;
  // Sign of the difference, flipped when it overflowed.
  assign less = sum[MSB] ^ ovf;

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    logic b_eff;
    logic slt_bit;
    assign b_eff = b[i] ^ ctrl.negate;
    if (i == 0) begin : g_lsb
      assign slt_bit = less;
    end else begin : g_upper
      assign slt_bit = 1'b0;
    end
    always_comb begin
      unique case (ctrl.sel)
        SEL_AND: result[i] = a[i] & b_eff;
        SEL_OR:  result[i] = a[i] | b_eff;
        SEL_SUM: result[i] = sum[i];
        default: result[i] = slt_bit;
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FUNCT_W = 6
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic [1:0]         alu_op,
  input  logic [FUNCT_W-1:0] funct,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow,
  output logic               carry_out
);
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic             add_cout;
  logic             add_ovf;
  logic             arith;

  alu_ctrl_dec #(.FUNCT_W(FUNCT_W)) u_dec (
    .alu_op (alu_op),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .a      (a),
    .b      (b),
    .negate (ctrl.negate),
    .sum    (sum),
    .c_out  (add_cout),
    .ovf    (add_ovf)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .ctrl   (ctrl),
    .a      (a),
    .b      (b),
    .sum    (sum),
    .ovf    (add_ovf),
    .result (result)
  );

  assign arith     = ctrl.sel[1];
  assign overflow  = arith & add_ovf;
  assign carry_out = arith & add_cout;
  assign zero      = ~|result;
endmodule

// File: rtl/alu_checks.sv
module alu_checks
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [1:0]       alu_op,
  input alu_ctrl_t        ctrl,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carry_out
);
  always_comb begin
    assert_class_add_R1: assert (alu_op != 2'b00 || ctrl == CTRL_ADD);
    assert_class_sub_R1: assert (alu_op != 2'b01 || ctrl == CTRL_SUB);
    assert_and_subset_R2: assert (ctrl != CTRL_AND || (result & ~a) == '0);
    assert_equal_sub_R4: assert (!(ctrl == CTRL_SUB && a == b) || (zero && carry_out));
    assert_slt_upper_R6: assert (ctrl.sel != SEL_SLT || result[WIDTH-1:1] == '0);
    assert_logic_flags_R8: assert (ctrl.sel[1] || (!overflow && !carry_out));
  end
endmodule

bind alu_core alu_checks #(.WIDTH(WIDTH)) u_checks (
  .a         (a),
  .b         (b),
  .alu_op    (alu_op),
  .ctrl      (ctrl),
  .result    (result),
  .zero      (zero),
  .overflow  (overflow),
  .carry_out (carry_out)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] a, b;
  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] result;
  logic        zero, overflow, carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  alu_core u_alu_core (
    .a(a), .b(b), .alu_op(alu_op), .funct(funct),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Op codes of the model: 0 add, 1 sub, 2 and, 3 or, 4 slt
  function automatic int model_op(input logic [1:0] op, input logic [5:0] fn);
    if (op == 2'b00 || op == 2'b11) return 0;
    if (op == 2'b01) return 1;
    case (fn[3:0])
      4'b0010: return 1;
      4'b0100: return 2;
      4'b0101: return 3;
      4'b1010: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h op=%b fn=%b actual=%0h expected=%0h",
               tag, a, b, alu_op, funct, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv,
                       input logic [1:0] op, input logic [5:0] fn, input string tag);
    int     k;
    longint ua, ub, full;
    logic [31:0] er;
    logic   eo, ec;
    k = model_op(op, fn);
    ua = longint'(av);
    ub = longint'(bv);
    @(posedge clk);
    a = av; b = bv; alu_op = op; funct = fn;
    eo = 1'b0; ec = 1'b0;
    case (k)
      0: begin
        full = ua + ub;
        er = full[31:0];
        ec = full[32];
        eo = (av[31] == bv[31]) && (er[31] != av[31]);
      end
      1, 4: begin
        full = ua + ((~ub) & 64'hFFFF_FFFF) + 1;
        er = full[31:0];
        ec = full[32];
        eo = (av[31] != bv[31]) && (er[31] != av[31]);
        if (k == 4) er = ($signed(av) < $signed(bv)) ? 32'd1 : 32'd0;
      end
      2: er = av & bv;
      default: er = av | bv;
    endcase
    @(negedge clk);
    check({tag, " result"}, longint'(result), longint'(er));
    check("R7 zero", longint'(zero), longint'(er == 32'd0));
    check({tag, " overflow R5/R8"}, longint'(overflow), longint'(eo));
    check({tag, " carry_out R3/R4/R8"}, longint'(carry_out), longint'(ec));
  endtask

  initial begin
    a = '0; b = '0; alu_op = 2'b00; funct = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle result", longint'(result), 0);
    check("R7 idle zero", longint'(zero), 1);

    // Decode paths (R1)
    apply(32'd5, 32'd3, 2'b00, 6'b111111, "R1 class00 add");
    apply(32'd5, 32'd3, 2'b01, 6'b000100, "R1 class01 sub");
    apply(32'd5, 32'd3, 2'b11, 6'b000010, "R1 class11 add");
    apply(32'd5, 32'd3, 2'b10, 6'b110010, "R1 funct hi ignored sub");
    apply(32'd5, 32'd3, 2'b10, 6'b000111, "R1 unlisted funct add");
    // Corners
    apply(32'h7FFF_FFFF, 32'd1, 2'b00, 6'd0, "R3 R5 add overflow");
    apply(32'hFFFF_FFFF, 32'd1, 2'b00, 6'd0, "R3 add carry wrap");
    apply(32'h8000_0000, 32'd1, 2'b01, 6'd0, "R4 R5 sub overflow");
    apply(32'h1234_5678, 32'h1234_5678, 2'b01, 6'd0, "R4 R7 sub equal");
    apply(32'd1, 32'd2, 2'b01, 6'd0, "R4 sub borrow");
    apply(32'h8000_0000, 32'd1, 2'b10, 6'b101010, "R6 slt ovf true");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b10, 6'b101010, "R6 slt ovf false");
    apply(32'hFFFF_FFFF, 32'd0, 2'b10, 6'b101010, "R6 slt negative");
    apply(32'd7, 32'd7, 2'b10, 6'b101010, "R6 slt equal");
    apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'b10, 6'b100100, "R2 R8 and disjoint");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 6'b100101, "R2 R8 or ones");

    // Random patterns over every class and funct value
    for (int i = 0; i < 600; i++) begin
      logic [5:0] fn;
      logic [1:0] op;
      op = 2'($urandom);
      case (i % 6)
        0: fn = 6'b100000;
        1: fn = 6'b100010;
        2: fn = 6'b100100;
        3: fn = 6'b100101;
        4: fn = 6'b101010;
        default: fn = 6'($urandom);
      endcase
      if (i % 3 != 0) op = 2'b10;
      apply($urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom, op, fn, "R1-mix random R2 R3 R4 R6");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule